// File: doc/BRIEF.md
# Fetch-Stage Branch Direction and Target Predictor

This block sits next to the fetch stage of a pipelined processor and picks the next fetch address in the same cycle the current address is presented. It keeps two direct-mapped tables indexed by low address bits. The first is a table of 2-bit saturating direction counters. The second is a target cache whose entries hold a valid bit, a tag made from the upper address bits and a cached destination. When the target cache hits and the counter leans toward taken, fetch is steered to the cached destination at once, with no taken-branch bubble. In every other case fetch falls through to the next sequential word.

When a branch resolves later in the pipeline, the resolution port receives the branch address, the real direction and the real destination. It also receives the prediction that fetch issued for that branch, which the pipeline carries alongside the instruction. The block trains the counter and, for a taken branch, refreshes the target entry. One cycle later it raises a mispredict pulse so that the pipeline can flush. The resolution port has no back-pressure. Every cycle with `upd_valid_i` high is consumed in that cycle and applied at the next clock edge. The lookup path is purely combinational and always answers.

Top module: `bp_fetch_predictor`

## Requirements
- R1: After reset every fetch address yields `pred_taken_o`=0 and `pred_next_pc_o` = fetch address + 4, and `mispredict_o` is 0. All counters reset to 01 and all target entries reset to invalid.
- R2: When the target entry selected by address bits [5:2] is valid, its tag equals address bits [31:6], and the counter selected by address bits [7:2] has bit 1 set, the block predicts taken and drives the cached destination on `pred_next_pc_o` in the same cycle.
- R3: When the selected counter is 00 or 01, the prediction is not taken with address + 4, even if the target entry hits.
- R4: When the target entry misses (it is invalid or its tag differs), the prediction is not taken with address + 4, even if the counter is 10 or 11.
- R5: The counter encoding is 00 strong not-taken, 01 weak not-taken, 10 weak taken and 11 strong taken. A taken resolution increments the counter and a not-taken resolution decrements it, saturating at 11 and at 00. A strong state therefore needs two opposite outcomes in a row to flip the direction.
- R6: A taken resolution writes the entry's valid bit, tag and destination. A not-taken resolution leaves the target entry unchanged.
- R7: `mispredict_o` is high in the cycle after a resolution whose real direction differs from the supplied predicted direction.
- R8: `mispredict_o` is high in the cycle after a taken resolution that was predicted taken when the real destination differs from the supplied predicted next address.
- R9: `mispredict_o` is low in the cycle after a correct resolution and in the cycle after any cycle without `upd_valid_i`.
- R10: The target cache is direct-mapped. An address with the same index bits but a different tag misses. A taken resolution of such an address evicts the previous entry.
- R11: A lookup in the same cycle as a resolution sees the table contents from before that resolution. The new contents are visible from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc_i | input | 32 | Address being fetched this cycle |
| pred_taken_o | output | 1 | Fetch is redirected to a cached destination |
| pred_next_pc_o | output | 32 | Next fetch address |
| upd_valid_i | input | 1 | A branch resolution is presented this cycle |
| upd_pc_i | input | 32 | Address of the resolved branch |
| upd_taken_i | input | 1 | Real direction of the branch |
| upd_target_i | input | 32 | Real destination of the branch |
| upd_pred_taken_i | input | 1 | Direction that fetch predicted for this branch |
| upd_pred_next_pc_i | input | 32 | Next address that fetch predicted for this branch |
| mispredict_o | output | 1 | Flush request, one cycle after a wrong resolution |

## Verification
The bench drives a counter from strong taken through two not-taken outcomes and checks that direction flips only on the second one. If the saturation or the hysteresis were wrong, fetch would redirect too early or would wrap from 00 to 11. It aliases two addresses onto one target entry, once while the shared counter reads taken. A design that skipped the tag compare or the valid bit would redirect an unrelated address. It issues a resolution and a lookup of the same address in one cycle, which exposes a design that forwards the write and answers early. It also applies a taken resolution whose destination changed while the direction was right, which catches a flush keyed on direction alone.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef enum logic [1:0] {
    CTR_STRONG_NT = 2'b00,
    CTR_WEAK_NT   = 2'b01,
    CTR_WEAK_T    = 2'b10,
    CTR_STRONG_T  = 2'b11
  } ctr_e;

  localparam ctr_e CTR_RESET = CTR_WEAK_NT;

  // Saturating step of a direction counter toward the resolved outcome
  function automatic ctr_e ctr_step(input ctr_e cur, input logic taken);
    ctr_e nxt;
    nxt = cur;
    if (taken) begin
      if (cur != CTR_STRONG_T) nxt = ctr_e'(cur + 2'b01);
    end else begin
      if (cur != CTR_STRONG_NT) nxt = ctr_e'(cur - 2'b01);
    end
    return nxt;
  endfunction

  function automatic logic ctr_says_taken(input ctr_e cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/bp_counter_table.sv
module bp_counter_table #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_taken_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_taken_i
);
  import bp_pkg::*;

  localparam int DEPTH = 1 << IDX_W;

  ctr_e ctr_q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ctr
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctr_q[e] <= CTR_RESET;
      end else if (wr_en_i && (wr_idx_i == IDX_W'(e))) begin
        ctr_q[e] <= ctr_step(ctr_q[e], wr_taken_i);
      end
    end
  end

  assign rd_taken_o = ctr_says_taken(ctr_q[rd_idx_i]);

endmodule

// File: rtl/bp_target_buffer.sv
module bp_target_buffer #(
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 26,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [TAG_W-1:0]  rd_tag_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] target_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [ADDR_W-1:0] wr_target_i
);

  localparam int DEPTH = 1 << IDX_W;

  logic              vld_q [DEPTH];
  logic [TAG_W-1:0]  tag_q [DEPTH];
  logic [ADDR_W-1:0] dst_q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic sel;
    assign sel = wr_en_i && (wr_idx_i == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q[e] <= 1'b0;
      end else if (sel) begin
        vld_q[e] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        tag_q[e] <= wr_tag_i;
        dst_q[e] <= wr_target_i;
      end
    end
  end

  assign hit_o    = vld_q[rd_idx_i] && (tag_q[rd_idx_i] == rd_tag_i);
  assign target_o = dst_q[rd_idx_i];

endmodule

// File: rtl/bp_mispredict.sv
module bp_mispredict #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic              taken_i,
  input  logic [ADDR_W-1:0] target_i,
  input  logic              pred_taken_i,
  input  logic [ADDR_W-1:0] pred_next_i,
  output logic              flush_o
);

  logic dir_wrong;
  logic dst_wrong;
  logic flush_q;

  assign dir_wrong = taken_i != pred_taken_i;
  assign dst_wrong = taken_i && (target_i != pred_next_i);

  always_ff @(posedge clk) begin
    if (!rst_n) flush_q <= 1'b0;
    else        flush_q <= valid_i && (dir_wrong || dst_wrong);
  end

  assign flush_o = flush_q;

endmodule

// File: rtl/bp_fetch_predictor.sv
module bp_fetch_predictor #(
  parameter int PC_W      = 32,
  parameter int HIST_IDX_W = 6,
  parameter int TGT_IDX_W  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pc_i,
  output logic            pred_taken_o,
  output logic [PC_W-1:0] pred_next_pc_o,
  input  logic            upd_valid_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic            upd_taken_i,
  input  logic [PC_W-1:0] upd_target_i,
  input  logic            upd_pred_taken_i,
  input  logic [PC_W-1:0] upd_pred_next_pc_i,
  output logic            mispredict_o
);

  localparam int WORD_LSB = 2;
  localparam int TAG_LSB  = WORD_LSB + TGT_IDX_W;
  localparam int TAG_W    = PC_W - TAG_LSB;
  localparam logic [PC_W-1:0] SEQ_STEP = PC_W'(4);

  logic            bht_taken;
  logic            btb_hit;
  logic [PC_W-1:0] btb_target;
  logic            unused_upd_low;

  assign unused_upd_low = ^upd_pc_i[WORD_LSB-1:0];

  bp_counter_table #(.IDX_W(HIST_IDX_W)) u_hist (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_idx_i   (fetch_pc_i[WORD_LSB +: HIST_IDX_W]),
    .rd_taken_o (bht_taken),
    .wr_en_i    (upd_valid_i),
    .wr_idx_i   (upd_pc_i[WORD_LSB +: HIST_IDX_W]),
    .wr_taken_i (upd_taken_i)
  );

  bp_target_buffer #(.IDX_W(TGT_IDX_W), .TAG_W(TAG_W), .ADDR_W(PC_W)) u_tgt (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_idx_i    (fetch_pc_i[WORD_LSB +: TGT_IDX_W]),
    .rd_tag_i    (fetch_pc_i[PC_W-1:TAG_LSB]),
    .hit_o       (btb_hit),
    .target_o    (btb_target),
    .wr_en_i     (upd_valid_i && upd_taken_i),
    .wr_idx_i    (upd_pc_i[WORD_LSB +: TGT_IDX_W]),
    .wr_tag_i    (upd_pc_i[PC_W-1:TAG_LSB]),
    .wr_target_i (upd_target_i)
  );

  bp_mispredict #(.ADDR_W(PC_W)) u_flush (
    .clk          (clk),
    .rst_n        (rst_n),
    .valid_i      (upd_valid_i),
    .taken_i      (upd_taken_i),
    .target_i     (upd_target_i),
    .pred_taken_i (upd_pred_taken_i),
    .pred_next_i  (upd_pred_next_pc_i),
    .flush_o      (mispredict_o)
  );

  always_comb begin
    pred_taken_o   = btb_hit && bht_taken;
    pred_next_pc_o = pred_taken_o ? btb_target : fetch_pc_i + SEQ_STEP;
  end

endmodule

// File: rtl/bp_fetch_predictor_chk.sv
module bp_fetch_predictor_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] fetch_pc_i,
  input logic            pred_taken_o,
  input logic [PC_W-1:0] pred_next_pc_o,
  input logic            upd_valid_i,
  input logic            upd_taken_i,
  input logic [PC_W-1:0] upd_target_i,
  input logic            upd_pred_taken_i,
  input logic [PC_W-1:0] upd_pred_next_pc_i,
  input logic            mispredict_o,
  input logic            btb_hit,
  input logic            bht_taken
);

  // R7
  dir_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid_i && (upd_taken_i != upd_pred_taken_i) |=> mispredict_o);

  // R8
  dst_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid_i && upd_taken_i && upd_pred_taken_i &&
    (upd_target_i != upd_pred_next_pc_i) |=> mispredict_o);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid_i |=> !mispredict_o);

  // R4
  miss_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !btb_hit |-> !pred_taken_o);

  // R3
  weak_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bht_taken |-> !pred_taken_o);

  // R1
  fallthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_taken_o |-> pred_next_pc_o == fetch_pc_i + PC_W'(4));

endmodule

bind bp_fetch_predictor bp_fetch_predictor_chk #(.PC_W(PC_W)) chk_i (
  .clk                (clk),
  .rst_n              (rst_n),
  .fetch_pc_i         (fetch_pc_i),
  .pred_taken_o       (pred_taken_o),
  .pred_next_pc_o     (pred_next_pc_o),
  .upd_valid_i        (upd_valid_i),
  .upd_taken_i        (upd_taken_i),
  .upd_target_i       (upd_target_i),
  .upd_pred_taken_i   (upd_pred_taken_i),
  .upd_pred_next_pc_i (upd_pred_next_pc_i),
  .mispredict_o       (mispredict_o),
  .btb_hit            (btb_hit),
  .bht_taken          (bht_taken)
);

// File: tb/bp_fetch_predictor_tb_top.sv
module bp_fetch_predictor_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_pc_i = '0;
  logic        pred_taken_o;
  logic [31:0] pred_next_pc_o;
  logic        upd_valid_i = 1'b0;
  logic [31:0] upd_pc_i = '0;
  logic        upd_taken_i = 1'b0;
  logic [31:0] upd_target_i = '0;
  logic        upd_pred_taken_i = 1'b0;
  logic [31:0] upd_pred_next_pc_i = '0;
  logic        mispredict_o;

  always #5 clk = ~clk;

  bp_fetch_predictor dut_i (
    .clk                (clk),
    .rst_n              (rst_n),
    .fetch_pc_i         (fetch_pc_i),
    .pred_taken_o       (pred_taken_o),
    .pred_next_pc_o     (pred_next_pc_o),
    .upd_valid_i        (upd_valid_i),
    .upd_pc_i           (upd_pc_i),
    .upd_taken_i        (upd_taken_i),
    .upd_target_i       (upd_target_i),
    .upd_pred_taken_i   (upd_pred_taken_i),
    .upd_pred_next_pc_i (upd_pred_next_pc_i),
    .mispredict_o       (mispredict_o)
  );

  typedef struct {
    int          cyc;
    bit          is_flush;
    logic        exp_taken;
    logic [31:0] exp_next;
    string       req;
  } item_t;

  item_t sb[$];
  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;

  // Reference tables built from the requirements
  logic [1:0]  m_ctr [64];
  logic        m_vld [16];
  logic [25:0] m_tag [16];
  logic [31:0] m_dst [16];

  always @(posedge clk) cyc++;

  task automatic step(input logic [31:0] fpc, input logic uv, input logic [31:0] upc,
                      input logic ut, input logic [31:0] utgt, input logic upt,
                      input logic [31:0] unpc, input string rf, input string rm);
    item_t it;
    logic  et;
    @(negedge clk);
    fetch_pc_i = fpc; upd_valid_i = uv; upd_pc_i = upc; upd_taken_i = ut;
    upd_target_i = utgt; upd_pred_taken_i = upt; upd_pred_next_pc_i = unpc;
    et = m_ctr[fpc[7:2]][1] && m_vld[fpc[5:2]] && (m_tag[fpc[5:2]] == fpc[31:6]);
    it.cyc = cyc; it.is_flush = 0; it.exp_taken = et;
    it.exp_next = et ? m_dst[fpc[5:2]] : fpc + 32'd4; it.req = rf;
    sb.push_back(it);
    it.cyc = cyc + 1; it.is_flush = 1;
    it.exp_taken = uv && ((ut != upt) || (ut && (utgt != unpc)));
    it.exp_next = '0; it.req = rm;
    sb.push_back(it);
    if (uv) begin
      if (ut && m_ctr[upc[7:2]] != 2'b11) m_ctr[upc[7:2]] = m_ctr[upc[7:2]] + 2'b01;
      if (!ut && m_ctr[upc[7:2]] != 2'b00) m_ctr[upc[7:2]] = m_ctr[upc[7:2]] - 2'b01;
      if (ut) begin
        m_vld[upc[5:2]] = 1'b1; m_tag[upc[5:2]] = upc[31:6]; m_dst[upc[5:2]] = utgt;
      end
    end
  endtask

  task automatic look(input logic [31:0] fpc, input string rf);
    step(fpc, 1'b0, '0, 1'b0, '0, 1'b0, '0, rf, "R9 idle");
  endtask

  // Monitor: pops due items shortly before each rising edge
  initial begin
    forever begin
      @(negedge clk);
      #4;
      while (sb.size() > 0 && sb[0].cyc <= cyc) begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if (it.is_flush) begin
          if (mispredict_o !== it.exp_taken) begin
            errors++;
            $display("FAIL %s: mispredict=%0b expected %0b", it.req, mispredict_o, it.exp_taken);
          end
        end else if (pred_taken_o !== it.exp_taken || pred_next_pc_o !== it.exp_next) begin
          errors++;
          $display("FAIL %s: taken=%0b next=%h expected taken=%0b next=%h",
                   it.req, pred_taken_o, pred_next_pc_o, it.exp_taken, it.exp_next);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) m_ctr[i] = 2'b01;
    for (int i = 0; i < 16; i++) begin m_vld[i] = 1'b0; m_tag[i] = '0; m_dst[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #4;
    checks++;
    if (mispredict_o !== 1'b0 || pred_taken_o !== 1'b0 || pred_next_pc_o !== 32'h4) begin
      errors++;
      $display("FAIL R1 reset: flush=%0b taken=%0b next=%h expected 0 0 00000004",
               mispredict_o, pred_taken_o, pred_next_pc_o);
    end
    look(32'h100, "R1 fresh lookup");
    // taken, predicted not taken; same-cycle lookup sees old state
    step(32'h100, 1, 32'h100, 1, 32'h200, 0, 32'h104, "R11 same-cycle old view", "R7 dir wrong");
    look(32'h100, "R2 redirect to cached target");
    step(32'h100, 1, 32'h100, 1, 32'h200, 1, 32'h200, "R2 still taken", "R9 correct taken");
    step(32'h380, 1, 32'h100, 1, 32'h300, 1, 32'h200, "R1 other pc", "R8 target changed");
    look(32'h100, "R6 refreshed target");
    step(32'h100, 1, 32'h100, 0, 32'h0, 1, 32'h300, "R6 pre-update", "R7 taken->nt");
    look(32'h100, "R5 one nt from strong keeps taken");
    step(32'h100, 1, 32'h100, 0, 32'h0, 1, 32'h300, "R5 hysteresis", "R7 second wrong");
    look(32'h100, "R3 weak nt with hit");
    step(32'h8, 1, 32'h100, 0, 32'h0, 0, 32'h104, "R1 seq", "R9 correct nt");
    step(32'h8, 1, 32'h100, 0, 32'h0, 0, 32'h104, "R1 seq", "R9 correct nt sat");
    step(32'h8, 1, 32'h100, 1, 32'h300, 0, 32'h104, "R1 seq", "R7 nt->taken");
    look(32'h100, "R5 low saturation keeps nt");
    step(32'h8, 1, 32'h100, 1, 32'h300, 0, 32'h104, "R1 seq", "R7 again");
    look(32'h100, "R5 flips to taken");
    look(32'h500, "R4 alias miss with taken counter");
    step(32'h500, 0, 32'h100, 1, 32'h999, 0, 32'h0, "R10 alias", "R9 valid low ignored");
    step(32'h8, 1, 32'h500, 1, 32'h600, 0, 32'h504, "R1 seq", "R7 alias taken");
    look(32'h100, "R10 evicted entry misses");
    look(32'h500, "R10 new owner hits");
    step(32'h500, 1, 32'h500, 0, 32'h0, 1, 32'h600, "R10 new owner", "R7 nt");
    step(32'h500, 1, 32'h500, 0, 32'h0, 0, 32'h504, "R6 nt keeps entry", "R9 ok");
    look(32'h500, "R3 nt counter suppresses");
    look(32'h0, "R1 end idle");
    repeat (3) @(negedge clk);
    #4;
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R9 scoreboard drain: left=%0d expected 0", sb.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule